// File: doc/BRIEF.md
# Three-Wire Shadow-RAM Serial Memory Model

This block is a synthesizable device-side model of a small serial memory holding sixteen 16-bit words. It has two stores. The first is a non-volatile array whose contents are fixed by a parameter. The second is a volatile shadow RAM, which is all zeros after reset. All reads come from the shadow RAM. The shadow RAM only receives the non-volatile contents when a recall instruction is issued.

A host talks to the model over three wires: a chip enable, a serial clock and a serial data input. The model answers on a serial data output that has its own enable flag. Each transaction starts with an 8-bit instruction, sent most significant bit first and taken on rising serial-clock edges. A read instruction returns one addressed word, least significant bit first. The first data bit appears on the falling edge of the eighth instruction clock, so it needs no clock pulse of its own. A whole word therefore takes 23 clock pulses. There is no auto-incrementing address.

The model runs on a system clock that oversamples the serial lines. It is intended as the target when checking a read controller for this kind of memory.

Top module: `mem3w_device`

## Requirements
- R1: After reset, and whenever chip enable is low, `ser_out_en` is 0 and `ser_out` is 0.
- R2: The shadow RAM resets to zero, so a read issued before any recall returns 0x0000.
- R3: The instruction 0x85 copies all sixteen non-volatile words into the shadow RAM and leaves the output released. With the default preload, word n holds the byte 2n+1 in bits 15:8 and the byte 2n in bits 7:0 (word 0 = 0x0100, word 15 = 0x1F1E).
- R4: The instruction is shifted in MSB first on rising serial-clock edges while chip enable is high. A read instruction has bit 7 = 1, bits 6:3 = word address (MSB first) and bits 2:0 = 110.
- R5: On the falling edge of the eighth instruction clock of a read, `ser_out_en` rises and `ser_out` presents bit 0 of the addressed shadow word, with no extra clock.
- R6: Each later falling edge advances `ser_out` to the next higher bit, up to bit 15. `ser_in` has no effect while data is being shifted out.
- R7: The falling edge after bit 15 has been presented releases the output (`ser_out_en` = 0). No further word follows without a new instruction.
- R8: Dropping chip enable aborts any partial instruction or readout. The output is released, and the next transaction decodes from bit 0 again.
- R9: Instructions other than recall and read are ignored. The output stays released until chip enable drops, and the shadow RAM is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_en | input | 1 | Active-high chip enable; low ends any transaction |
| ser_clk | input | 1 | Serial clock from the host |
| ser_in | input | 1 | Serial instruction data, taken on rising ser_clk |
| ser_out | output | 1 | Serial read data, LSB first, updated on falling ser_clk |
| ser_out_en | output | 1 | High while ser_out carries a valid data bit |

## Verification
The hardest situation to reach from the ports is the boundary between the instruction and the data. Bit 0 appears on the same falling edge that completes the instruction, so a controller that adds an extra clock loses that bit. The stimulus therefore samples the output after every falling edge, from the eighth onward. It also drives random values on `ser_in` during readout. Aborted transactions are cut at a random bit position, both inside the instruction and inside the readout, and each is followed by a full read to show that decoding restarted. Unknown instructions are drawn at random, with the recall and read patterns excluded, and later reads show the shadow contents untouched.

// File: rtl/mem3w_pkg.sv
package mem3w_pkg;
  localparam int OP_W   = 8;
  localparam int ADDR_W = 4;
  localparam logic [OP_W-1:0] OP_RECALL = 8'h85;
  localparam logic [2:0]      READ_TAIL = 3'b110;

  // read instruction: leading one, address, fixed tail 110
  function automatic logic op_is_read(logic [OP_W-1:0] op);
    return op[OP_W-1] && (op[2:0] == READ_TAIL);
  endfunction

  function automatic logic [ADDR_W-1:0] op_addr(logic [OP_W-1:0] op);
    return op[OP_W-2 -: ADDR_W];
  endfunction

  // default preload: high byte 2n+1+base, low byte 2n+base
  function automatic logic [15:0] preload_word(int unsigned idx, int unsigned base);
    logic [7:0] lo, hi;
    lo = 8'((2 * idx + base) & 255);
    hi = 8'((2 * idx + 1 + base) & 255);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/mem3w_shifter.sv
module mem3w_shifter
  import mem3w_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel,
  input  logic            sclk,
  input  logic            sdi,
  output logic            sclk_fall,
  output logic            op_done,
  output logic [OP_W-1:0] op
);
  localparam int CNT_W = $clog2(OP_W + 1);

  logic             sclk_q;
  logic             sclk_rise;
  logic [CNT_W-1:0] cnt;
  logic             fired;

  assign sclk_rise = sclk && !sclk_q;
  assign sclk_fall = !sclk && sclk_q;
  assign op_done   = sel && sclk_fall && (cnt == CNT_W'(OP_W)) && !fired;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cnt    <= '0;
      op     <= '0;
      fired  <= 1'b0;
    end else begin
      sclk_q <= sclk;
      if (!sel) begin
        cnt   <= '0;
        op    <= '0;
        fired <= 1'b0;
      end else begin
        if (sclk_rise && (cnt < CNT_W'(OP_W))) begin
          cnt <= cnt + 1'b1;
          op  <= {op[OP_W-2:0], sdi};
        end
        if (op_done) fired <= 1'b1;
      end
    end
  end

  // R8: chip enable low clears the bit counter
  p_abort_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (cnt == '0));
  // R4: one decode per transaction
  p_single_decode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done);
endmodule

// File: rtl/mem3w_store.sv
module mem3w_store
  import mem3w_pkg::*;
#(
  parameter int WORDS   = 16,
  parameter int WIDTH   = 16,
  parameter int NV_BASE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              recall,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WIDTH-1:0]  rd_word
);
  logic [WORDS-1:0][WIDTH-1:0] nv;
  logic [WORDS-1:0][WIDTH-1:0] shadow;

  for (genvar i = 0; i < WORDS; i++) begin : g_nv
    assign nv[i] = WIDTH'(preload_word(i, NV_BASE));
    // R3: every word equals its non-volatile copy after recall
    p_recall_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      recall |=> (shadow[i] == nv[i]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      shadow <= '0;
    else if (recall) shadow <= nv;
  end

  assign rd_word = shadow[rd_addr];

  // R9: shadow changes only on recall
  p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !recall |=> $stable(shadow));
endmodule

// File: rtl/mem3w_serout.sv
module mem3w_serout #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             fall,
  input  logic             load,
  input  logic [WIDTH-1:0] word_in,
  output logic             dout,
  output logic             dout_oe
);
  localparam int IDX_W = $clog2(WIDTH);

  logic [WIDTH-1:0] word_q;
  logic [IDX_W-1:0] idx;
  logic             last_bit;

  assign last_bit = (idx == IDX_W'(WIDTH - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q  <= '0;
      idx     <= '0;
      dout_oe <= 1'b0;
    end else if (!sel) begin
      idx     <= '0;
      dout_oe <= 1'b0;
    end else if (load) begin
      word_q  <= word_in;
      idx     <= '0;
      dout_oe <= 1'b1;
    end else if (dout_oe && fall) begin
      if (last_bit) dout_oe <= 1'b0;
      else          idx     <= idx + 1'b1;
    end
  end

  assign dout = dout_oe ? word_q[idx] : 1'b0;

  // R1/R8: output released after chip enable drops
  p_release_on_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (!dout_oe && !dout));
  // R5: read decode presents bit 0 at once
  p_first_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && load) |=> (dout_oe && idx == '0 && dout == word_in[0]));
  // R6: each falling edge moves one bit up
  p_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !load && dout_oe && fall && !last_bit) |=>
      (dout_oe && idx == $past(idx) + 1'b1));
  // R7: release after bit 15
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !load && dout_oe && fall && last_bit) |=> !dout_oe);
endmodule

// File: rtl/mem3w_device.sv
module mem3w_device
  import mem3w_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int NV_BASE = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_en,
  input  logic ser_clk,
  input  logic ser_in,
  output logic ser_out,
  output logic ser_out_en
);
  localparam int WORDS = 1 << ADDR_W;

  logic            sclk_fall;
  logic            op_done;
  logic [OP_W-1:0] op;
  logic            recall_strobe;
  logic            read_strobe;
  logic [WIDTH-1:0] rd_word;

  mem3w_shifter u_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (chip_en),
    .sclk      (ser_clk),
    .sdi       (ser_in),
    .sclk_fall (sclk_fall),
    .op_done   (op_done),
    .op        (op)
  );

  assign recall_strobe = op_done && (op == OP_RECALL);
  assign read_strobe   = op_done && op_is_read(op);

  mem3w_store #(.WORDS(WORDS), .WIDTH(WIDTH), .NV_BASE(NV_BASE)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .recall  (recall_strobe),
    .rd_addr (op_addr(op)),
    .rd_word (rd_word)
  );

  mem3w_serout #(.WIDTH(WIDTH)) u_serout (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (chip_en),
    .fall    (sclk_fall),
    .load    (read_strobe),
    .word_in (rd_word),
    .dout    (ser_out),
    .dout_oe (ser_out_en)
  );

  // R9: a decoded non-read instruction never enables the output
  p_ignored_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !read_strobe && !ser_out_en) |=> !ser_out_en);
endmodule

// File: tb/test_mem3w_device.sv
module test_mem3w_device;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_en = 1'b0;
  logic ser_clk = 1'b0;
  logic ser_in = 1'b0;
  logic ser_out, ser_out_en;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [15:0] shadow_m [16];

  always #5 clk = ~clk;

  mem3w_device i_mem3w_device (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .ser_clk(ser_clk),
    .ser_in(ser_in), .ser_out(ser_out), .ser_out_en(ser_out_en)
  );

  function automatic logic [15:0] nv_expect(int n);
    logic [7:0] b0, b1;
    b0 = 8'(n * 2);
    b1 = 8'(n * 2 + 1);
    return (16'(b1) << 8) | 16'(b0);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    ser_clk = 1'b1; tick(2);
    ser_clk = 1'b0; tick(2);
  endtask

  task automatic send_bits(logic [7:0] op, int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      ser_in = op[i];
      tick(1);
      pulse();
    end
  endtask

  task automatic deselect();
    chip_en = 1'b0; tick(2);
    chk("R8 release", {ser_out_en, ser_out}, 0);
  endtask

  task automatic read_word(int addr, int stop_at);
    logic [15:0] got;
    logic oe_ok;
    got = '0; oe_ok = 1'b1;
    chip_en = 1'b1; tick(1);
    send_bits({1'b1, 4'(addr), 3'b110}, 8);
    for (int b = 0; b < 16 && b < stop_at; b++) begin
      if (b > 0) begin ser_in = 1'($urandom); tick(1); pulse(); end
      got[b] = ser_out;
      if (ser_out_en !== 1'b1) oe_ok = 1'b0;
    end
    if (stop_at >= 16) begin
      chk("R5/R6 enable held for 16 bits", 32'(oe_ok), 1);
      chk("R4/R6 word LSB first", 32'(got), 32'(shadow_m[addr]));
      pulse();
      chk("R7 released after bit 15", 32'(ser_out_en), 0);
    end
    deselect();
  endtask

  task automatic send_op(logic [7:0] op);
    chip_en = 1'b1; tick(1);
    send_bits(op, 8);
    chk("R9/R3 output released after non-read", 32'(ser_out_en), 0);
    pulse(); pulse();
    chk("R9 stays released", 32'(ser_out_en), 0);
    if (op == 8'h85) for (int k = 0; k < 16; k++) shadow_m[k] = nv_expect(k);
    deselect();
  endtask

  task automatic junk_op();
    logic [7:0] op;
    op = 8'($urandom);
    while (op == 8'h85 || (op[7] && op[2:0] == 3'b110)) op = 8'($urandom);
    send_op(op);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_3a11));
    for (int k = 0; k < 16; k++) shadow_m[k] = '0;
    tick(4);
    chk("R1 reset output", {ser_out_en, ser_out}, 0);
    rst_n = 1'b1; tick(2);
    chk("R1 idle output", {ser_out_en, ser_out}, 0);

    read_word(0, 16);   // R2 zero before recall
    read_word(15, 16);
    chk("R2 pre-recall", 32'(shadow_m[15]), 0);

    junk_op();          // R9 ignored
    read_word(3, 16);

    chip_en = 1'b1; tick(1);   // R8 abort mid-instruction
    send_bits(8'hFE, 5);
    deselect();
    read_word(7, 16);
    read_word(9, 4);    // R8 abort mid-readout
    read_word(9, 16);

    send_op(8'h85);     // R3 recall
    read_word(0, 16);
    chk("R3 word 0", 32'(shadow_m[0]), 32'h0100);
    read_word(15, 16);
    chk("R3 word 15", 32'(shadow_m[15]), 32'h1F1E);

    for (int t = 0; t < 80; t++) begin
      case ($urandom % 5)
        0, 1, 2: read_word(int'($urandom % 16), 16);
        3: junk_op();
        default: begin
          if ($urandom % 2) begin
            chip_en = 1'b1; tick(1);
            send_bits(8'($urandom), 1 + int'($urandom % 7));
            deselect();
          end else read_word(int'($urandom % 16), 1 + int'($urandom % 15));
        end
      endcase
    end
    send_op(8'h85);
    read_word(10, 16);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule